// File: doc/BRIEF.md
# Mode-Aware Port Register Bank

This block holds the data and direction registers of three 8-bit general-purpose ports (A, B and E) behind a small synchronous register bus. Each register sits at a fixed offset. A 2-bit operating-mode input and an emulate-E flag decide, on every access, whether a register answers from on-chip storage or is handed to an external replacement unit. An external access is flagged with a one-cycle strobe, and no on-chip data comes back for it.

Each port drives pin output values and per-pin output enables. Reading a port's data register returns a mix: pins that are outputs give back the latched value, and pins that are inputs give back the live pin level. Port E has two bits that are permanently inputs. A per-pin alternate-function mask lets bus-control logic take port E pins away from the direction register.

Top module: `gpio_port_bank`

## Requirements
- R1: Registers decode at fixed offsets: data A 0x0, data B 0x1, direction A 0x2, direction B 0x3, data E 0x8, direction E 0x9. A write stores the write data, and a later read returns it.
- R2: Reset (synchronous, active high) clears all data and direction registers, so every output enable is 0. Both `bus_rdata` and `bus_ext` are also 0.
- R3: A direction bit of 1 drives the corresponding `pin_x_oe` bit to 1, with `pin_x_out` carrying the data register. A direction bit of 0 leaves the pin as a high-impedance input (oe 0).
- R4: Reading a data register returns, per bit, the latched value when that pin's output enable is 1 and the `pin_x_in` level when it is 0.
- R5: In the modes expanded-wide (op_mode 1), expanded-narrow (2) and peripheral (3), accesses to offsets 0x0 to 0x3 are external. They raise `bus_ext` for one cycle, return 0 and leave the registers unchanged.
- R6: Offsets 0x8 and 0x9 are external in peripheral mode, and in the expanded modes when `emul_e` is 1. They are on-chip in the expanded modes when `emul_e` is 0. In single-chip mode (op_mode 0), every register is on-chip whatever the value of `emul_e`.
- R7: Port E bits 1 and 0 are input only. Their direction bits always read 0 and their output enables stay 0, while their pin levels remain readable through data E.
- R8: A 1 in `alt_e` forces that port E pin's output enable to 0, whatever its direction bit holds. Data E readback then returns the pin level for that bit.
- R9: An access to any other offset changes nothing, returns 0 and does not raise `bus_ext`.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 2 | 0 single-chip, 1 expanded wide, 2 expanded narrow, 3 peripheral |
| emul_e | input | 1 | Emulate port E externally in expanded modes |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_ext | output | 1 | One-cycle strobe for an externally mapped access |
| alt_e | input | 8 | Port E pins taken by alternate bus-control functions |
| pin_a_in | input | 8 | Port A pin levels |
| pin_b_in | input | 8 | Port B pin levels |
| pin_e_in | input | 8 | Port E pin levels |
| pin_a_out | output | 8 | Port A output values |
| pin_a_oe | output | 8 | Port A output enables |
| pin_b_out | output | 8 | Port B output values |
| pin_b_oe | output | 8 | Port B output enables |
| pin_e_out | output | 8 | Port E output values |
| pin_e_oe | output | 8 | Port E output enables |

## Verification
The bench targets writes in non-single-chip modes. A design that fails to block them would overwrite port A, and single-chip readback afterwards would show the overwrite. It sets `emul_e` in single-chip mode, where a design that honours the flag would wrongly send port E off chip. It also writes all ones to direction E: a design without the input-only mask would read 0xFF and enable the two interrupt pins. Finally, it raises `alt_e` and unmapped offsets, where a design would keep the pin driven or answer a phantom register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned NPORT = 3;

  typedef enum logic [1:0] {
    MD_SINGLE     = 2'd0,
    MD_EXP_WIDE   = 2'd1,
    MD_EXP_NARROW = 2'd2,
    MD_PERIPH     = 2'd3
  } op_mode_e;

  // port index order: 0 = A, 1 = B, 2 = E
  localparam logic [AW-1:0] OFF_DAT [NPORT] = '{4'h0, 4'h1, 4'h8};
  localparam logic [AW-1:0] OFF_DIR [NPORT] = '{4'h2, 4'h3, 4'h9};
  localparam logic [DW-1:0] IN_ONLY [NPORT] = '{8'h00, 8'h00, 8'h03};
endpackage

// File: rtl/gpio_map_decode.sv
module gpio_map_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned AWIDTH = AW,
  parameter int unsigned PORTS  = NPORT
) (
  input  logic              sel,
  input  logic [AWIDTH-1:0] addr,
  input  logic [1:0]        mode,
  input  logic              emul,
  output logic [PORTS-1:0]  dat_hit,
  output logic [PORTS-1:0]  dir_hit,
  output logic              ext_hit
);
  logic single_chip;
  logic periph;
  logic [PORTS-1:0] onchip;
  logic [PORTS-1:0] dat_match;
  logic [PORTS-1:0] dir_match;

  assign single_chip = (mode == MD_SINGLE);
  assign periph      = (mode == MD_PERIPH);

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      if (p == PORTS - 1) begin : g_emul
        assign onchip[p] = single_chip | (!periph & !emul);
      end else begin : g_plain
        assign onchip[p] = single_chip;
      end
      assign dat_match[p] = sel && (addr == OFF_DAT[p]);
      assign dir_match[p] = sel && (addr == OFF_DIR[p]);
      assign dat_hit[p]   = dat_match[p] & onchip[p];
      assign dir_hit[p]   = dir_match[p] & onchip[p];
    end
  endgenerate

  assign ext_hit = |((dat_match | dir_match) & ~onchip);
endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       FIXED_IN = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dat,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] alt_mask,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] dat_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_dat) dat_q <= wdata;
      if (wr_dir) dir_q <= wdata & ~FIXED_IN;
    end
  end

  assign oe     = dir_q & ~alt_mask & ~FIXED_IN;
  assign dat_rd = (dat_q & oe) | (pin_in & ~oe);
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = DW,
  parameter int unsigned AWID  = AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_mode,
  input  logic             emul_e,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AWID-1:0]  bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             bus_ext,
  input  logic [WIDTH-1:0] alt_e,
  input  logic [WIDTH-1:0] pin_a_in,
  input  logic [WIDTH-1:0] pin_b_in,
  input  logic [WIDTH-1:0] pin_e_in,
  output logic [WIDTH-1:0] pin_a_out,
  output logic [WIDTH-1:0] pin_a_oe,
  output logic [WIDTH-1:0] pin_b_out,
  output logic [WIDTH-1:0] pin_b_oe,
  output logic [WIDTH-1:0] pin_e_out,
  output logic [WIDTH-1:0] pin_e_oe
);
  localparam int unsigned P = NPORT;

  logic [P-1:0]     dat_hit, dir_hit;
  logic             ext_hit;
  logic [WIDTH-1:0] pin_in_v [P];
  logic [WIDTH-1:0] alt_v    [P];
  logic [WIDTH-1:0] dat_q_v  [P];
  logic [WIDTH-1:0] dir_q_v  [P];
  logic [WIDTH-1:0] oe_v     [P];
  logic [WIDTH-1:0] rd_v     [P];
  logic [WIDTH-1:0] rd_mux;

  assign pin_in_v[0] = pin_a_in;
  assign pin_in_v[1] = pin_b_in;
  assign pin_in_v[2] = pin_e_in;
  assign alt_v[0]    = '0;
  assign alt_v[1]    = '0;
  assign alt_v[2]    = alt_e;

  gpio_map_decode #(.AWIDTH(AWID), .PORTS(P)) u_dec (
    .sel     (bus_sel),
    .addr    (bus_addr),
    .mode    (op_mode),
    .emul    (emul_e),
    .dat_hit (dat_hit),
    .dir_hit (dir_hit),
    .ext_hit (ext_hit)
  );

  generate
    for (genvar p = 0; p < P; p++) begin : g_prt
      gpio_port_reg #(.W(WIDTH), .FIXED_IN(IN_ONLY[p])) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_dat   (dat_hit[p] & bus_wr),
        .wr_dir   (dir_hit[p] & bus_wr),
        .wdata    (bus_wdata),
        .alt_mask (alt_v[p]),
        .pin_in   (pin_in_v[p]),
        .dat_q    (dat_q_v[p]),
        .dir_q    (dir_q_v[p]),
        .oe       (oe_v[p]),
        .dat_rd   (rd_v[p])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < P; p++) begin
      if (dat_hit[p]) rd_mux = rd_mux | rd_v[p];
      if (dir_hit[p]) rd_mux = rd_mux | dir_q_v[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_ext   <= 1'b0;
    end else begin
      bus_rdata <= bus_wr ? '0 : rd_mux;
      bus_ext   <= ext_hit;
    end
  end

  assign pin_a_out = dat_q_v[0];
  assign pin_a_oe  = oe_v[0];
  assign pin_b_out = dat_q_v[1];
  assign pin_b_oe  = oe_v[1];
  assign pin_e_out = dat_q_v[2];
  assign pin_e_oe  = oe_v[2];
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] op_mode,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       bus_ext,
  input logic [7:0] alt_e,
  input logic [7:0] pin_a_out,
  input logic [7:0] pin_a_oe,
  input logic [7:0] pin_b_oe,
  input logic [7:0] pin_e_oe
);
  // R2
  reset_clears_oe_chk: assert property (@(posedge clk)
    $past(rst) |-> (pin_a_oe == 8'h00 && pin_b_oe == 8'h00 && pin_e_oe == 8'h00));

  // R5
  port_a_frozen_off_chip_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) != 2'd0) |-> $stable(pin_a_out));

  // R5
  ext_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ext |-> ($past(bus_sel) && $past(op_mode) != 2'd0));

  // R7
  e_low_pins_input_chk: assert property (@(posedge clk) disable iff (rst)
    pin_e_oe[1:0] == 2'b00);

  // R8
  alt_overrides_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_e_oe & alt_e) == 8'h00);

  // R10
  rdata_only_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata != 8'h00) |-> ($past(bus_sel) && !$past(bus_wr)));
endmodule

bind gpio_port_bank gpio_port_bank_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_mode   (op_mode),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .bus_ext   (bus_ext),
  .alt_e     (alt_e),
  .pin_a_out (pin_a_out),
  .pin_a_oe  (pin_a_oe),
  .pin_b_oe  (pin_b_oe),
  .pin_e_oe  (pin_e_oe)
);

// File: tb/gpio_port_bank_tb_top.sv
module gpio_port_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_mode = 2'd0;
  logic       emul_e = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ext;
  logic [7:0] alt_e = 8'h00;
  logic [7:0] pin_a_in = 8'h5A;
  logic [7:0] pin_b_in = 8'hC3;
  logic [7:0] pin_e_in = 8'h96;
  logic [7:0] pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, pin_e_out, pin_e_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_bank dut_i (.*);

  // {req[3:0], mode[1:0], emul, wr, addr[3:0], wdata[7:0], exp_rd[7:0], exp_ext}
  localparam logic [28:0] VEC [NV] = '{
    {4'd2,  2'd0, 1'b0, 1'b0, 4'h2, 8'h00, 8'h00, 1'b0}, // R2 dir A after reset
    {4'd1,  2'd0, 1'b0, 1'b1, 4'h2, 8'hF0, 8'h00, 1'b0}, // R1 write dir A
    {4'd1,  2'd0, 1'b0, 1'b1, 4'h0, 8'h3C, 8'h00, 1'b0}, // R1 write data A
    {4'd4,  2'd0, 1'b0, 1'b0, 4'h0, 8'h00, 8'h3A, 1'b0}, // R4 mixed readback
    {4'd1,  2'd0, 1'b0, 1'b0, 4'h2, 8'h00, 8'hF0, 1'b0}, // R1 read dir A
    {4'd1,  2'd0, 1'b0, 1'b1, 4'h3, 8'hFF, 8'h00, 1'b0}, // R1 write dir B
    {4'd1,  2'd0, 1'b0, 1'b1, 4'h1, 8'h81, 8'h00, 1'b0}, // R1 write data B
    {4'd4,  2'd0, 1'b0, 1'b0, 4'h1, 8'h00, 8'h81, 1'b0}, // R4 all outputs
    {4'd7,  2'd0, 1'b0, 1'b1, 4'h9, 8'hFF, 8'h00, 1'b0}, // R7 write dir E
    {4'd7,  2'd0, 1'b0, 1'b0, 4'h9, 8'h00, 8'hFC, 1'b0}, // R7 dir E low bits 0
    {4'd7,  2'd0, 1'b0, 1'b1, 4'h8, 8'hFF, 8'h00, 1'b0}, // R7 write data E
    {4'd7,  2'd0, 1'b0, 1'b0, 4'h8, 8'h00, 8'hFE, 1'b0}, // R7 low pins readable
    {4'd9,  2'd0, 1'b0, 1'b0, 4'h4, 8'h00, 8'h00, 1'b0}, // R9 unmapped read
    {4'd9,  2'd0, 1'b0, 1'b1, 4'h5, 8'hFF, 8'h00, 1'b0}, // R9 unmapped write
    {4'd5,  2'd1, 1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1}, // R5 A external
    {4'd5,  2'd1, 1'b0, 1'b1, 4'h0, 8'h00, 8'h00, 1'b1}, // R5 write ignored
    {4'd5,  2'd0, 1'b0, 1'b0, 4'h0, 8'h00, 8'h3A, 1'b0}, // R5 A unchanged
    {4'd6,  2'd1, 1'b0, 1'b0, 4'h8, 8'h00, 8'hFE, 1'b0}, // R6 E on chip
    {4'd6,  2'd1, 1'b1, 1'b0, 4'h8, 8'h00, 8'h00, 1'b1}, // R6 E emulated
    {4'd6,  2'd2, 1'b1, 1'b1, 4'h9, 8'h00, 8'h00, 1'b1}, // R6 write ignored
    {4'd6,  2'd3, 1'b0, 1'b0, 4'h9, 8'h00, 8'h00, 1'b1}, // R6 peripheral
    {4'd6,  2'd0, 1'b1, 1'b0, 4'h9, 8'h00, 8'hFC, 1'b0}, // R6 single ignores emul
    {4'd5,  2'd2, 1'b0, 1'b0, 4'h3, 8'h00, 8'h00, 1'b1}  // R5 narrow external
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] m, input logic em, input logic wr,
                        input logic [3:0] a, input logic [7:0] d);
    op_mode = m; emul_e = em; bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state at the ports
    check8("R2 oe A", pin_a_oe, 8'h00);
    check8("R2 oe B", pin_b_oe, 8'h00);
    check8("R2 oe E", pin_e_oe, 8'h00);
    check8("R2 out A", pin_a_out, 8'h00);
    check8("R2 rdata", bus_rdata, 8'h00);
    check8("R2 ext", {7'd0, bus_ext}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][24:23], VEC[i][22], VEC[i][21], VEC[i][20:17], VEC[i][16:9]);
      check8($sformatf("R%0d vec%0d rdata", VEC[i][28:25], i), bus_rdata, VEC[i][8:1]);
      check8($sformatf("R%0d vec%0d ext", VEC[i][28:25], i), {7'd0, bus_ext}, {7'd0, VEC[i][0]});
    end

    // R10 / R5: idle cycle after a request returns zero and drops strobe
    op_mode = 2'd0; emul_e = 1'b0;
    @(negedge clk);
    check8("R10 idle rdata", bus_rdata, 8'h00);
    check8("R5 strobe one cycle", {7'd0, bus_ext}, 8'h00);

    // R3 pin drive
    check8("R3 out A", pin_a_out, 8'h3C);
    check8("R3 oe A", pin_a_oe, 8'hF0);
    check8("R3 oe B", pin_b_oe, 8'hFF);
    check8("R3 out B", pin_b_out, 8'h81);
    check8("R7 oe E", pin_e_oe, 8'hFC);

    // R8 alternate function override
    alt_e = 8'h80; pin_e_in = 8'h00;
    @(negedge clk);
    check8("R8 oe E", pin_e_oe, 8'h7C);
    access(2'd0, 1'b0, 1'b0, 4'h8, 8'h00);
    check8("R8 readback E", bus_rdata, 8'h7C);
    access(2'd0, 1'b0, 1'b0, 4'h9, 8'h00);
    check8("R8 dir E kept", bus_rdata, 8'hFC);
    alt_e = 8'h00;

    // R4 pin level changes on inputs
    pin_a_in = 8'h0F;
    access(2'd0, 1'b0, 1'b0, 4'h0, 8'h00);
    check8("R4 input follows pin", bus_rdata, 8'h3F);

    // R2 mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check8("R2 oe A after reset", pin_a_oe, 8'h00);
    access(2'd0, 1'b0, 1'b0, 4'h3, 8'h00);
    check8("R2 dir B after reset", bus_rdata, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule